// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. When a burst begins, it registers the full external address. The upper part of that address is held for the length of the burst. The low bits come from a small burst counter combined with the starting offset. Each advance request moves the burst to the next word within its aligned group.

The group is four words at the default width. The step order is set by a mode pin:

- **Linear** order counts upward and wraps within the group.
- **Interleaved** order XORs the starting offset with a running count.

A burst can be started from two places:

- The controller-side strobe always loads.
- The processor-side strobe loads only while the chip-enable qualification is high.

When neither strobe nor advance is active, the address holds.

Top module: `bas_seq`

## Requirements
- R1: While `rst_n` is low, the registered state clears, and `mem_addr` reads 0 from the first clock edge in reset onward.
- R2: When `ctrl_start` is high at a rising edge, `ext_addr` is captured whatever the level of `cpu_en`. After that edge, `mem_addr` equals the captured address.
- R3: When `cpu_start` and `cpu_en` are both high at a rising edge, `ext_addr` is captured. After that edge, `mem_addr` equals it.
- R4: When `cpu_start` is high while `cpu_en` is low and `ctrl_start` is low, no capture takes place. `mem_addr` behaves exactly as it would without the strobe.
- R5: A start strobe and `adv` in the same cycle act as a start: the new address is captured and the burst count restarts at 0. The controller-side strobe has priority over the processor-side strobe.
- R6: With `order_sel` = 0 (linear), after n advances the low two bits of `mem_addr` equal (start offset + n) mod 4.
- R7: With `order_sel` = 1 (interleaved), after n advances the low two bits of `mem_addr` equal start offset XOR (n mod 4).
- R8: Advances never change `mem_addr[19:2]`. A burst wraps within its aligned 4-word group with no carry out of bit 1.
- R9: When no strobe is accepted, `adv` is low and `order_sel` is steady, `mem_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | 20 | External word address captured at burst start |
| ctrl_start | input | 1 | Controller-side burst start; loads unconditionally |
| cpu_start | input | 1 | Processor-side burst start; qualified by `cpu_en` |
| cpu_en | input | 1 | Chip-enable qualification for `cpu_start` |
| adv | input | 1 | Step to the next word of the burst |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| mem_addr | output | 20 | Current array word address |

## Verification
The bench builds the sequencer with its default widths: a 20-bit address and a 2-bit burst field. With a four-word group, random runs of advances reach every starting offset and every wrap point in both orders within a few cycles. The 18-bit upper field is drawn as fully random values, including all-ones, so a carry out of the burst field would show at once. Directed cases cover the strobe combined with advance, the unqualified processor strobe, and a change of mode in the middle of a burst.

// File: rtl/bas_pkg.sv
package bas_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_STEP = 2'd2
   } seq_act_e;

endpackage

// File: rtl/bas_start_arb.sv
module bas_start_arb
   import bas_pkg::*;
(
   input  logic     ctrl_start,
   input  logic     cpu_start,
   input  logic     cpu_en,
   input  logic     adv,
   output seq_act_e act
);

   // Controller strobe first, qualified processor strobe next, advance last.
   always_comb begin
      if (ctrl_start)
         act = ACT_LOAD;
      else if (cpu_start && cpu_en)
         act = ACT_LOAD;
      else if (adv)
         act = ACT_STEP;
      else
         act = ACT_HOLD;
   end

endmodule

// File: rtl/bas_addr_reg.sv
module bas_addr_reg
   import bas_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int BURST_W = 2,
   localparam int UPPER_W = ADDR_W - BURST_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  seq_act_e           act,
   input  logic [ADDR_W-1:0]  ext_addr,
   output logic [UPPER_W-1:0] upper_q,
   output logic [BURST_W-1:0] start_q,
   output logic [BURST_W-1:0] cnt_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upper_q <= '0;
         start_q <= '0;
         cnt_q   <= '0;
      end else begin
         case (act)
            ACT_LOAD: begin
               upper_q <= ext_addr[ADDR_W-1:BURST_W];
               start_q <= ext_addr[BURST_W-1:0];
               cnt_q   <= '0;
            end
            ACT_STEP: cnt_q <= cnt_q + 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
   import bas_pkg::*;
#(
   parameter int BURST_W = 2
) (
   input  burst_order_e       order,
   input  logic [BURST_W-1:0] start_ofs,
   input  logic [BURST_W-1:0] cnt,
   output logic [BURST_W-1:0] low
);

   logic [BURST_W-1:0] lin_ofs;
   logic [BURST_W-1:0] ilv_ofs;

   // Modular sum: the carry out of the top bit is dropped, so the burst wraps.
   assign lin_ofs = start_ofs + cnt;

   for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
      assign ilv_ofs[b] = start_ofs[b] ^ cnt[b];
   end

   assign low = (order == ORD_INTERLEAVE) ? ilv_ofs : lin_ofs;

endmodule

// File: rtl/bas_seq.sv
module bas_seq
   import bas_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              ctrl_start,
   input  logic              cpu_start,
   input  logic              cpu_en,
   input  logic              adv,
   input  logic              order_sel,
   output logic [ADDR_W-1:0] mem_addr
);

   localparam int UPPER_W = ADDR_W - BURST_W;

   if (BURST_W < 1) begin : g_bad_burst
      $error("bas_seq: BURST_W must be at least 1");
   end
   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("bas_seq: ADDR_W must exceed BURST_W");
   end

   seq_act_e           act;
   logic [UPPER_W-1:0] upper_q;
   logic [BURST_W-1:0] start_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] low_ofs;
   burst_order_e       order;

   assign order = burst_order_e'(order_sel);

   bas_start_arb u_arb (
      .ctrl_start (ctrl_start),
      .cpu_start  (cpu_start),
      .cpu_en     (cpu_en),
      .adv        (adv),
      .act        (act)
   );

   bas_addr_reg #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .ext_addr (ext_addr),
      .upper_q  (upper_q),
      .start_q  (start_q),
      .cnt_q    (cnt_q)
   );

   bas_order_map #(.BURST_W(BURST_W)) u_map (
      .order     (order),
      .start_ofs (start_q),
      .cnt       (cnt_q),
      .low       (low_ofs)
   );

   assign mem_addr = {upper_q, low_ofs};

endmodule

// File: rtl/bas_seq_chk.sv
module bas_seq_chk #(
   parameter int ADDR_W  = 20,
   parameter int BURST_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              ctrl_start,
   input logic              cpu_start,
   input logic              cpu_en,
   input logic              adv,
   input logic              order_sel,
   input logic [ADDR_W-1:0] mem_addr
);

   logic take;
   assign take = ctrl_start || (cpu_start && cpu_en);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> mem_addr == '0);

   // R2
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_start |=> mem_addr == $past(ext_addr));

   // R3
   cpu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_start && cpu_en) |=> mem_addr == $past(ext_addr));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !adv) |=> (order_sel != $past(order_sel)) || (mem_addr == $past(mem_addr)));

   // R8
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && adv) |=> mem_addr[ADDR_W-1:BURST_W] == $past(mem_addr[ADDR_W-1:BURST_W]));

   // R6
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && adv && !order_sel) |=>
         order_sel || (mem_addr[BURST_W-1:0] == BURST_W'($past(mem_addr[BURST_W-1:0]) + 1'b1)));

endmodule

bind bas_seq bas_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (.*);

// File: tb/bas_seq_test.sv
`timescale 1ns/1ps
module bas_seq_test;

   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          ctrl_start = 1'b0;
   logic          cpu_start = 1'b0;
   logic          cpu_en = 1'b0;
   logic          adv = 1'b0;
   logic          order_sel = 1'b0;
   logic [AW-1:0] mem_addr;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // reference state
   logic [AW-3:0] r_up  = '0;
   logic [1:0]    r_ofs = '0;
   logic [1:0]    r_cnt = '0;

   always #2.5 clk = ~clk;

   bas_seq uut (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .ctrl_start(ctrl_start),
      .cpu_start(cpu_start), .cpu_en(cpu_en), .adv(adv), .order_sel(order_sel),
      .mem_addr(mem_addr)
   );

   function automatic logic [AW-1:0] expect_addr(logic [AW-3:0] up, logic [1:0] ofs,
                                                 logic [1:0] cnt, logic mode);
      logic [1:0] lo;
      lo = mode ? (ofs ^ cnt) : 2'(ofs + cnt);
      return {up, lo};
   endfunction

   task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
      end
   endtask

   // Drive one cycle at the falling edge, update the reference at the rising edge, compare after it.
   task automatic step(logic [AW-1:0] a, logic cs, logic ps, logic en, logic ad, logic md,
                       string req);
      @(negedge clk);
      ext_addr = a; ctrl_start = cs; cpu_start = ps; cpu_en = en; adv = ad; order_sel = md;
      @(posedge clk);
      if (cs || (ps && en)) begin
         r_up = a[AW-1:2]; r_ofs = a[1:0]; r_cnt = 2'd0;
      end else if (ad) begin
         r_cnt = r_cnt + 2'd1;
      end
      #1;
      check(req, mem_addr, expect_addr(r_up, r_ofs, r_cnt, md));
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] hold_v;
      void'($urandom(32'd5151));
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1: cleared during reset
      check("R1", mem_addr, '0);
      @(negedge clk); rst_n = 1'b1;

      // R2: controller strobe loads with cpu_en low
      step(20'hABCD6, 1, 0, 0, 0, 0, "R2");
      // R6: linear from offset 2 -> 3,0,1,2
      for (int i = 0; i < 5; i++) step(20'h00000, 0, 0, 0, 1, 0, "R6");
      // R8: all-ones upper with offset 3, advances never carry
      step(20'hFFFFF, 1, 0, 0, 0, 0, "R2");
      for (int i = 0; i < 4; i++) begin
         step(20'h00000, 0, 0, 0, 1, 0, "R8");
         check("R8", {mem_addr[AW-1:2], 2'b00}, 20'hFFFFC);
      end
      // R3: qualified processor strobe
      step(20'h12341, 0, 1, 1, 0, 1, "R3");
      // R7: interleaved from offset 1 -> 0,3,2,1
      for (int i = 0; i < 4; i++) step(20'h00000, 0, 0, 0, 1, 1, "R7");
      check("R7", mem_addr, 20'h12341);
      // R4: unqualified processor strobe ignored
      hold_v = mem_addr;
      step(20'h55550, 0, 1, 0, 0, 1, "R4");
      check("R4", mem_addr, hold_v);
      // R9: idle holds
      step(20'h77777, 0, 0, 1, 0, 1, "R9");
      check("R9", mem_addr, hold_v);
      // R5: strobe with advance restarts the count
      step(20'h0F0F2, 0, 1, 1, 1, 0, "R5");
      check("R5", mem_addr, 20'h0F0F2);
      step(20'h3C3C1, 1, 1, 0, 1, 0, "R5");
      check("R5", mem_addr, 20'h3C3C1);

      // random mix
      for (int i = 0; i < 1500; i++) begin
         logic [AW-1:0] a;
         logic cs, ps, en, ad, md;
         string tag;
         a  = AW'($urandom);
         cs = ($urandom % 8) == 0;
         ps = ($urandom % 6) == 0;
         en = $urandom % 2;
         ad = ($urandom % 3) != 0;
         md = (($urandom % 16) == 0) ? ~order_sel : order_sel;
         if (cs) tag = "R2";
         else if (ps && en) tag = "R3";
         else if (ad) tag = md ? "R7" : "R6";
         else if (ps) tag = "R4";
         else tag = "R9";
         step(a, cs, ps, en, ad, md, tag);
      end

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule